// File: doc/BRIEF.md
# Register Redirection and Predicate Lookup

This block sits between instruction decode and register read. A scalar instruction names up to three architectural registers with 5-bit numbers, all of one class (integer or floating-point). The block looks each number up in a small table of tags and returns a 7-bit physical register number, a vector flag and an element-width code for each operand. For the destination operand it also returns the predicate to apply: the predicate register, invert, zeroing and fail-on-first flags. It also returns a flag that marks the mask as all ones.

The tables are filled through a plain configuration strobe carrying one entry per cycle, either a full 16-bit entry or a compact 8-bit entry in the low byte. Entries are kept in decoded form: one slot per class and architectural register, so a lookup is a direct index and needs no key compare. Reset empties both tables.

Lookups are a valid/ready stream with a single registered response stage. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. A response waiting with `rsp_ready` low stays unchanged until it is taken, and no new request is accepted during that time.

Top module: `srp_redirect`

## Requirements
- R1: After reset both tables are empty and `rsp_valid` is low. A looked-up operand with no active entry comes back as a scalar (vector flag 0), with its own number zero-extended to 7 bits and width code 00, and the destination has no predication.
- R2: A full register entry (`cfg_pred`=0, `cfg_compact`=0) uses these fields: key number in bits 4:0, class in bit 5 (1 integer, 0 floating-point), width code in bits 7:6, target in bits 14:8 and scalar-mode in bit 15. A hit returns the target as the physical number, the width code as given and vector flag = NOT bit 15. Width codes are 00 default, 01 8-bit, 10 16-bit, 11 32-bit.
- R3: A compact register entry (`cfg_compact`=1) uses bits 7:0 only: the key, the class and the width code at the same positions as R2. A hit returns target = key shifted left by two and is always a vector.
- R4: Integer and floating-point tables are separate. An entry written for one class never changes a lookup of the other class with the same number.
- R5: A full predicate entry (`cfg_pred`=1, `cfg_compact`=0) uses these fields: key in bits 4:0, class in bit 5, invert in bit 6, zeroing in bit 7, predicate register in bits 14:8 and fail-on-first in bit 15.
- R6: A compact predicate entry uses the key, class, invert and zeroing fields of R5. Its predicate register is the key plus 9, and its fail-on-first flag is 0.
- R7: Predication is reported only when the destination has an active register entry as well as an active predicate entry. Otherwise `rsp_pred_en` is 0 and every predicate output is 0.
- R8: `rsp_pred_ones` is 1 exactly when predication is reported with predicate register 0 and invert set.
- R9: A later entry for the same class and key replaces the earlier one. A request accepted in the same cycle as a table write sees the table as it was before that write.
- R10: A request accepted at a clock edge gives `rsp_valid` high after that edge, carrying its result. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_pred | input | 1 | 1 writes the predicate table, 0 the register table |
| cfg_compact | input | 1 | 1 selects the compact 8-bit entry in bits 7:0 |
| cfg_entry | input | 16 | Entry to write |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_int | input | 1 | 1 integer operands, 0 floating-point |
| req_regs | input | 15 | Three 5-bit numbers; slot 0 (bits 4:0) is the destination |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken by the consumer |
| rsp_phys | output | 21 | Three 7-bit physical numbers, same slot order |
| rsp_vec | output | 3 | Vector flag per slot |
| rsp_ew | output | 6 | Two-bit width code per slot |
| rsp_pred_en | output | 1 | Destination is predicated |
| rsp_pred_reg | output | 7 | Predicate register |
| rsp_pred_inv | output | 1 | Invert mask |
| rsp_pred_zero | output | 1 | Zero masked-off elements |
| rsp_pred_ffirst | output | 1 | Fail-on-first |
| rsp_pred_ones | output | 1 | Mask is all ones |

## Verification
The hardest case to reach from the ports is a table change that overlaps a lookup of the same key. This covers a write and a request that land on the same edge, and writes that arrive while a finished response is stalled by back-pressure. The stimulus drives one directed edge where both strobes hit the same integer key. A random phase then keeps keys in a narrow range, drops `rsp_ready` often and writes often, so stalls with table updates underneath them occur many times. A cycle-by-cycle reference model follows every accept, drain and write, and each response is compared with it.

// File: rtl/srp_pkg.sv
package srp_pkg;
  parameter int ARCH_W    = 5;
  parameter int PHYS_W    = 7;
  parameter int EW_W      = 2;
  parameter int ENT_W     = 16;
  parameter int PRED_BASE = 9;

  localparam int NCLS      = 2;
  localparam int NARCH     = 2 ** ARCH_W;
  localparam int CMP_SHIFT = PHYS_W - ARCH_W;

  // decoded register tag for one architectural register
  typedef struct packed {
    logic              act;
    logic              scal;
    logic [EW_W-1:0]   ew;
    logic [PHYS_W-1:0] tgt;
  } rmap_t;

  // decoded predicate tag for one architectural destination
  typedef struct packed {
    logic              act;
    logic              inv;
    logic              zero;
    logic              ffirst;
    logic [PHYS_W-1:0] preg;
  } pmap_t;
endpackage

// File: rtl/srp_entry_decode.sv
module srp_entry_decode
  import srp_pkg::*;
(
  input  logic             wr_valid,
  input  logic             wr_pred,
  input  logic             wr_compact,
  input  logic [ENT_W-1:0] wr_data,
  output logic             reg_we,
  output logic             pred_we,
  output logic [ARCH_W-1:0] key,
  output logic             cls,
  output rmap_t            rnew,
  output pmap_t            pnew
);
  localparam int F_CLS = ARCH_W;
  localparam int F_A   = ARCH_W + 1;
  localparam int F_B   = ARCH_W + 2;
  localparam int F_TGT = ENT_W - 1 - PHYS_W;
  localparam int F_TOP = ENT_W - 1;

  assign reg_we  = wr_valid && !wr_pred;
  assign pred_we = wr_valid && wr_pred;
  assign key     = wr_data[ARCH_W-1:0];
  assign cls     = wr_data[F_CLS];

  always_comb begin
    rnew      = '0;
    rnew.act  = 1'b1;
    rnew.ew   = wr_data[F_A +: EW_W];
    if (wr_compact) begin
      rnew.tgt  = {key, {CMP_SHIFT{1'b0}}};
      rnew.scal = 1'b0;
    end else begin
      rnew.tgt  = wr_data[F_TGT +: PHYS_W];
      rnew.scal = wr_data[F_TOP];
    end
  end

  always_comb begin
    pnew      = '0;
    pnew.act  = 1'b1;
    pnew.inv  = wr_data[F_A];
    pnew.zero = wr_data[F_B];
    if (wr_compact) begin
      pnew.preg   = PHYS_W'(key) + PHYS_W'(PRED_BASE);
      pnew.ffirst = 1'b0;
    end else begin
      pnew.preg   = wr_data[F_TGT +: PHYS_W];
      pnew.ffirst = wr_data[F_TOP];
    end
  end
endmodule

// File: rtl/srp_kv_table.sv
module srp_kv_table
  import srp_pkg::*;
#(
  parameter type ENT_T = rmap_t,
  parameter int  NPORT = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic                    wcls,
  input  logic [ARCH_W-1:0]       wkey,
  input  ENT_T                    wval,
  input  logic [NPORT-1:0]        rcls,
  input  logic [NPORT*ARCH_W-1:0] rkey,
  output ENT_T                    rval [NPORT]
);
  ENT_T mem [NCLS][NARCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCLS; c++)
        for (int k = 0; k < NARCH; k++)
          mem[c][k] <= '0;
    end else if (we) begin
      mem[wcls][wkey] <= wval;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rval[p] = mem[rcls[p]][rkey[p*ARCH_W +: ARCH_W]];
  end
endmodule

// File: rtl/srp_opnd_xlate.sv
module srp_opnd_xlate
  import srp_pkg::*;
(
  input  logic [ARCH_W-1:0] arch,
  input  rmap_t             ent,
  output logic [PHYS_W-1:0] phys,
  output logic              vec,
  output logic [EW_W-1:0]   ew
);
  always_comb begin
    if (ent.act) begin
      phys = ent.tgt;
      vec  = !ent.scal;
      ew   = ent.ew;
    end else begin
      phys = PHYS_W'(arch);
      vec  = 1'b0;
      ew   = '0;
    end
  end
endmodule

// File: rtl/srp_pred_gate.sv
module srp_pred_gate
  import srp_pkg::*;
(
  input  logic              reg_act,
  input  pmap_t             pent,
  output logic              pen,
  output logic [PHYS_W-1:0] preg,
  output logic              inv,
  output logic              zero,
  output logic              ffirst,
  output logic              ones
);
  always_comb begin
    pen    = reg_act && pent.act;
    preg   = pen ? pent.preg : '0;
    inv    = pen && pent.inv;
    zero   = pen && pent.zero;
    ffirst = pen && pent.ffirst;
    ones   = pen && pent.inv && (pent.preg == '0);
  end
endmodule

// File: rtl/srp_redirect.sv
module srp_redirect
  import srp_pkg::*;
#(
  parameter int NOPS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic                     cfg_pred,
  input  logic                     cfg_compact,
  input  logic [ENT_W-1:0]         cfg_entry,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_int,
  input  logic [NOPS*ARCH_W-1:0]   req_regs,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [NOPS*PHYS_W-1:0]   rsp_phys,
  output logic [NOPS-1:0]          rsp_vec,
  output logic [NOPS*EW_W-1:0]     rsp_ew,
  output logic                     rsp_pred_en,
  output logic [PHYS_W-1:0]        rsp_pred_reg,
  output logic                     rsp_pred_inv,
  output logic                     rsp_pred_zero,
  output logic                     rsp_pred_ffirst,
  output logic                     rsp_pred_ones
);
  logic              reg_we, pred_we, w_cls;
  logic [ARCH_W-1:0] w_key;
  rmap_t             rnew;
  pmap_t             pnew;

  srp_entry_decode u_dec (
    .wr_valid   (cfg_we),
    .wr_pred    (cfg_pred),
    .wr_compact (cfg_compact),
    .wr_data    (cfg_entry),
    .reg_we     (reg_we),
    .pred_we    (pred_we),
    .key        (w_key),
    .cls        (w_cls),
    .rnew       (rnew),
    .pnew       (pnew)
  );

  logic [NOPS-1:0] rd_cls;
  rmap_t           r_ent [NOPS];
  pmap_t           p_ent [1];

  assign rd_cls = {NOPS{req_int}};

  srp_kv_table #(.ENT_T(rmap_t), .NPORT(NOPS)) u_rtab (
    .clk  (clk),
    .rst  (rst),
    .we   (reg_we),
    .wcls (w_cls),
    .wkey (w_key),
    .wval (rnew),
    .rcls (rd_cls),
    .rkey (req_regs),
    .rval (r_ent)
  );

  srp_kv_table #(.ENT_T(pmap_t), .NPORT(1)) u_ptab (
    .clk  (clk),
    .rst  (rst),
    .we   (pred_we),
    .wcls (w_cls),
    .wkey (w_key),
    .wval (pnew),
    .rcls (req_int),
    .rkey (req_regs[ARCH_W-1:0]),
    .rval (p_ent)
  );

  logic [NOPS*PHYS_W-1:0] n_phys;
  logic [NOPS-1:0]        n_vec;
  logic [NOPS*EW_W-1:0]   n_ew;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    srp_opnd_xlate u_x (
      .arch (req_regs[g*ARCH_W +: ARCH_W]),
      .ent  (r_ent[g]),
      .phys (n_phys[g*PHYS_W +: PHYS_W]),
      .vec  (n_vec[g]),
      .ew   (n_ew[g*EW_W +: EW_W])
    );
  end

  logic              n_pen, n_inv, n_zero, n_ff, n_ones;
  logic [PHYS_W-1:0] n_preg;

  srp_pred_gate u_pg (
    .reg_act (r_ent[0].act),
    .pent    (p_ent[0]),
    .pen     (n_pen),
    .preg    (n_preg),
    .inv     (n_inv),
    .zero    (n_zero),
    .ffirst  (n_ff),
    .ones    (n_ones)
  );

  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_phys        <= '0;
      rsp_vec         <= '0;
      rsp_ew          <= '0;
      rsp_pred_en     <= 1'b0;
      rsp_pred_reg    <= '0;
      rsp_pred_inv    <= 1'b0;
      rsp_pred_zero   <= 1'b0;
      rsp_pred_ffirst <= 1'b0;
      rsp_pred_ones   <= 1'b0;
    end else if (accept) begin
      rsp_valid       <= 1'b1;
      rsp_phys        <= n_phys;
      rsp_vec         <= n_vec;
      rsp_ew          <= n_ew;
      rsp_pred_en     <= n_pen;
      rsp_pred_reg    <= n_preg;
      rsp_pred_inv    <= n_inv;
      rsp_pred_zero   <= n_zero;
      rsp_pred_ffirst <= n_ff;
      rsp_pred_ones   <= n_ones;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/srp_redirect_chk.sv
module srp_redirect_chk
  import srp_pkg::*;
#(
  parameter int NOPS = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [NOPS*PHYS_W-1:0] rsp_phys,
  input logic [NOPS-1:0]        rsp_vec,
  input logic [NOPS*EW_W-1:0]   rsp_ew,
  input logic                   rsp_pred_en,
  input logic [PHYS_W-1:0]      rsp_pred_reg,
  input logic                   rsp_pred_inv,
  input logic                   rsp_pred_zero,
  input logic                   rsp_pred_ffirst,
  input logic                   rsp_pred_ones
);
  p_empty_after_reset_r1: assert property (@(posedge clk)
    rst |=> !rsp_valid);

  p_accept_gives_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);

  p_stall_holds_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_phys) && $stable(rsp_vec)
      && $stable(rsp_ew) && $stable(rsp_pred_en) && $stable(rsp_pred_reg)
      && $stable(rsp_pred_ones));

  p_drain_empties_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && !req_valid |=> !rsp_valid);

  p_pred_gated_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_pred_en |-> rsp_pred_reg == '0 && !rsp_pred_inv
      && !rsp_pred_zero && !rsp_pred_ffirst && !rsp_pred_ones);

  p_ones_meaning_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_pred_ones |-> rsp_pred_en && rsp_pred_inv && rsp_pred_reg == '0);
endmodule

bind srp_redirect srp_redirect_chk #(.NOPS(NOPS)) u_chk (.*);

// File: tb/srp_redirect_tb.sv
`timescale 1ns/1ps
module srp_redirect_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_pred = 1'b0, cfg_compact = 1'b0;
  logic [15:0] cfg_entry = '0;
  logic        req_valid = 1'b0, req_int = 1'b0, rsp_ready = 1'b1;
  logic [14:0] req_regs = '0;
  logic        req_ready, rsp_valid;
  logic [20:0] rsp_phys;
  logic [2:0]  rsp_vec;
  logic [5:0]  rsp_ew;
  logic        rsp_pred_en, rsp_pred_inv, rsp_pred_zero, rsp_pred_ffirst, rsp_pred_ones;
  logic [6:0]  rsp_pred_reg;

  always #10 clk = ~clk;

  srp_redirect dut_i (.*);

  int n_cmp = 0, n_bad = 0;
  string ph = "R1 reset";

  // reference model state
  int m_ract[2][32], m_rscal[2][32], m_rew[2][32], m_rtgt[2][32];
  int m_pact[2][32], m_pinv[2][32], m_pzero[2][32], m_pff[2][32], m_preg[2][32];
  bit e_valid = 0;
  int e_phys[3], e_vec[3], e_ew[3];
  int e_pen, e_preg, e_inv, e_zero, e_ff, e_ones;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", tag, ph, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit acc;
    int c, k;
    if (rst) begin
      e_valid = 0;
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 32; j++) begin
          m_ract[i][j] = 0; m_pact[i][j] = 0;
        end
      return;
    end
    acc = req_valid && (!e_valid || rsp_ready);
    if (acc) begin
      c = req_int;
      for (int o = 0; o < 3; o++) begin
        int a = (req_regs >> (5*o)) & 31;
        if (m_ract[c][a] != 0) begin
          e_phys[o] = m_rtgt[c][a]; e_vec[o] = 1 - m_rscal[c][a]; e_ew[o] = m_rew[c][a];
        end else begin
          e_phys[o] = a; e_vec[o] = 0; e_ew[o] = 0;
        end
      end
      k = req_regs & 31;
      if (m_ract[c][k] != 0 && m_pact[c][k] != 0) begin
        e_pen = 1; e_preg = m_preg[c][k]; e_inv = m_pinv[c][k];
        e_zero = m_pzero[c][k]; e_ff = m_pff[c][k];
        e_ones = (e_inv != 0 && e_preg == 0) ? 1 : 0;
      end else begin
        e_pen = 0; e_preg = 0; e_inv = 0; e_zero = 0; e_ff = 0; e_ones = 0;
      end
      e_valid = 1;
    end else if (rsp_ready) begin
      e_valid = 0;
    end
    if (cfg_we) begin
      k = cfg_entry & 31;
      c = (cfg_entry >> 5) & 1;
      if (cfg_pred) begin
        m_pact[c][k] = 1;
        m_pinv[c][k] = (cfg_entry >> 6) & 1;
        m_pzero[c][k] = (cfg_entry >> 7) & 1;
        m_preg[c][k] = cfg_compact ? k + 9 : (cfg_entry >> 8) & 127;
        m_pff[c][k] = cfg_compact ? 0 : (cfg_entry >> 15) & 1;
      end else begin
        m_ract[c][k] = 1;
        m_rew[c][k] = (cfg_entry >> 6) & 3;
        m_rtgt[c][k] = cfg_compact ? k * 4 : (cfg_entry >> 8) & 127;
        m_rscal[c][k] = cfg_compact ? 0 : (cfg_entry >> 15) & 1;
      end
    end
  endtask

  task automatic compare();
    chk("R10", "rsp_valid", rsp_valid, e_valid);
    chk("R10", "req_ready", req_ready, (!e_valid || rsp_ready) ? 1 : 0);
    if (e_valid && rsp_valid) begin
      for (int o = 0; o < 3; o++) begin
        chk("R2", $sformatf("phys[%0d]", o), (rsp_phys >> (7*o)) & 127, e_phys[o]);
        chk("R3", $sformatf("vec[%0d]", o), (rsp_vec >> o) & 1, e_vec[o]);
        chk("R2", $sformatf("ew[%0d]", o), (rsp_ew >> (2*o)) & 3, e_ew[o]);
      end
      chk("R7", "pred_en", rsp_pred_en, e_pen);
      chk("R5", "pred_reg", rsp_pred_reg, e_preg);
      chk("R5", "pred_inv", rsp_pred_inv, e_inv);
      chk("R5", "pred_zero", rsp_pred_zero, e_zero);
      chk("R6", "pred_ffirst", rsp_pred_ffirst, e_ff);
      chk("R8", "pred_ones", rsp_pred_ones, e_ones);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic put(bit pred, bit compact, int data);
    cfg_we = 1; cfg_pred = pred; cfg_compact = compact; cfg_entry = 16'(data);
    tick();
    cfg_we = 0;
  endtask

  task automatic look(bit is_int, int rd, int s1, int s2);
    req_valid = 1; req_int = is_int; req_regs = 15'((s2 << 10) | (s1 << 5) | rd);
    tick();
    req_valid = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    tick();

    ph = "R1 passthrough";
    look(1, 3, 4, 5);
    look(0, 31, 0, 17);
    tick();

    ph = "R2 full register";
    put(0, 0, (100 << 8) | (2 << 6) | (1 << 5) | 3);
    ph = "R3 compact register";
    put(0, 1, (1 << 6) | (1 << 5) | 7);
    ph = "R4 class separation";
    put(0, 0, (1 << 15) | (55 << 8) | (3 << 6) | 3);
    look(1, 3, 7, 3);
    look(0, 3, 7, 4);

    ph = "R8 all ones";
    put(1, 0, (1 << 15) | (1 << 6) | (1 << 5) | 3);
    look(1, 3, 0, 0);
    ph = "R6 compact predicate";
    put(1, 1, (1 << 7) | (1 << 5) | 7);
    look(1, 7, 3, 3);
    ph = "R5 full predicate";
    put(1, 0, (42 << 8) | (1 << 7) | 9);
    ph = "R7 predicate needs register tag";
    look(0, 9, 1, 2);
    put(0, 1, 9);
    look(0, 9, 1, 2);

    ph = "R9 same-cycle write";
    cfg_we = 1; cfg_pred = 0; cfg_compact = 1; cfg_entry = 16'((3 << 6) | (1 << 5) | 3);
    req_valid = 1; req_int = 1; req_regs = 15'(3);
    tick();
    cfg_we = 0;
    tick();
    req_valid = 0;
    tick();

    ph = "R10 back-pressure";
    rsp_ready = 0;
    look(1, 7, 3, 1);
    req_valid = 1; req_regs = 15'(3);
    put(0, 0, (9 << 8) | (1 << 5) | 7);
    repeat (3) tick();
    rsp_ready = 1;
    tick();
    req_valid = 0;
    tick();
    tick();

    ph = "random";
    for (int n = 0; n < 3000; n++) begin
      int key = $urandom % 8;
      cfg_we = ($urandom % 10) < 3;
      cfg_pred = $urandom % 2;
      cfg_compact = $urandom % 2;
      cfg_entry = 16'(($urandom & 16'hffc0) | (($urandom % 2) << 5) | key);
      req_valid = ($urandom % 4) != 0;
      req_int = $urandom % 2;
      req_regs = 15'((($urandom % 8) << 10) | (($urandom % 8) << 5) |
                     (($urandom % 6 == 0) ? ($urandom % 32) : ($urandom % 8)));
      rsp_ready = ($urandom % 3) != 0;
      tick();
    end
    cfg_we = 0; req_valid = 0; rsp_ready = 1;
    tick();
    tick();
    finish_run();
  end
endmodule